// File: doc/BRIEF.md
# Peripheral Halfword Register Bank

This block is the register file that sits between a processor bus and a set of on-chip peripherals: display status, a scanline counter, sound control, a DMA channel, a timer, memory wait-states, a serial port, interrupts and a debug switch. Every register is 16 bits wide. Each one has its own rule for writes and reads: some bits are masked off, some are live status bits that a write cannot change, the interrupt flags are cleared by writing ones, some registers cannot be read back, some reads are gated by an enable bit, and one register has no stored bits at all. The bank only stores values and shapes reads. The peripherals themselves live elsewhere and see the stored values through a flat output vector.

The bus takes byte, halfword and word requests in a single cycle. A word access is handled as two halfword lanes, one at the aligned address and one at that address plus 2. A byte write is first merged with the stored halfword, and the register's own write rule is then applied to the merged value. Read data, the read-valid strobe and an error strobe for unmapped addresses all appear one clock after the request.

Halfword slot map (byte offset): 0x00 display status, 0x02 scanline counter, 0x04 sound master, 0x06 and 0x08 sound channel controls, 0x0A DMA count, 0x0C and 0x0E DMA address low and high, 0x10 timer control, 0x12 wait-state control, 0x14 serial mode, 0x16 interrupt enable, 0x18 interrupt flags, 0x1A debug switch. Slot n occupies bits [16n+15:16n] of `reg_view`.

Top module: `periph_regbank`

## Requirements
- R1: A byte write (size 2'b00) takes its data from wdata[7:0]. An odd address replaces bits [15:8] of the halfword and an even address replaces bits [7:0]; the other byte keeps its stored value before the register's write rule is applied. A byte read returns the selected byte in rdata[7:0].
- R2: A word access (size 2'b1x) ignores addr[1:0]. wdata[15:0] goes to the aligned halfword and wdata[31:16] to the aligned address plus 2, in the same cycle. A word read returns the upper halfword in rdata[31:16] and the lower one in rdata[15:0].
- R3: In the interrupt-flag register (0x18), an irq_set bit sets the matching flag. A write clears every flag whose bit is 1 in the merged write value; because bytes are merged first, a byte write also clears the set bits of the byte it did not address. A set and a clear in the same cycle leave the bit set. No flag rises without irq_set.
- R4: The scanline counter (0x02) reads as line_in zero-extended. Writes to it change nothing.
- R5: The display status register (0x00) stores only bits [15:3] of a write. Its bits [2:0] always read as stat_in.
- R6: The sound master register (0x04) stores only bit 7 of a write. It reads as {8'h00, bit 7, 3'b000, chan_in}.
- R7: While bit 7 of the sound master register is 0, reads of the sound channel controls (0x06, 0x08) return 0. Writes are still stored, and the stored value reads back once the bit is 1.
- R8: The DMA count and address registers (0x0A, 0x0C, 0x0E) always read as 0. Written values are stored and appear on reg_view.
- R9: Writes are masked with 16'h00C7 for timer control (0x10), 16'h5FFF for wait-state control (0x12) and 16'hC1FF for serial mode (0x14).
- R10: Storing 16'hC0DE in the debug switch (0x1A) raises dbg_on, and any other value lowers it. While dbg_on is 1, a read of 0x1A returns 16'h1DEA; otherwise it returns 0.
- R11: An access to a halfword slot beyond 0x1A stores nothing and reads as 0. err pulses high in the next cycle; for a word access it pulses if either lane misses.
- R12: After reset every stored slot is 0. rdata and rvalid are registered, valid one cycle after a read request, and rvalid is 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus request, one access per cycle |
| we | input | 1 | 1 for a write, 0 for a read |
| size | input | 2 | 00 byte, 01 halfword, 1x word |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the request |
| rvalid | output | 1 | rdata is valid this cycle |
| err | output | 1 | Previous access touched an unmapped slot |
| stat_in | input | 3 | Live display status bits |
| line_in | input | LINE_W | Current scanline number |
| chan_in | input | 4 | Live sound channel-active bits |
| irq_set | input | 16 | Interrupt set pulses |
| reg_view | output | 224 | All stored slots, slot n at [16n+15:16n] |
| dbg_on | output | 1 | Debug mode active |

## Verification
On every cycle the assertions check that no interrupt flag rises without a set pulse, that the masked registers never hold a bit outside their masks, and that err and rvalid only follow a matching request. They also check that reads of the scanline counter, of the debug switch while unlocked, of gated sound channels and of unmapped slots return their fixed values. The directed scenarios are needed for the value-dependent effects: byte merging into each half, the word split across two registers, the same-cycle set-versus-clear case, the cross-byte clear caused by merging, and the write-only registers whose stored value can only be seen on reg_view.

// File: rtl/regbank_pkg.sv
// Shared constants and write rules for the peripheral register bank.
// Assumes 16-bit slots indexed by halfword address; slot order is fixed
// because the peripherals decode reg_view by position.
package regbank_pkg;

    localparam int unsigned HW     = 16;
    localparam int unsigned NREG   = 14;
    localparam int unsigned STAT_W = 3;
    localparam int unsigned CHAN_W = 4;

    localparam int unsigned IDX_STAT = 0;
    localparam int unsigned IDX_LINE = 1;
    localparam int unsigned IDX_SNDM = 2;
    localparam int unsigned IDX_CH0  = 3;
    localparam int unsigned IDX_CH1  = 4;
    localparam int unsigned IDX_DCNT = 5;
    localparam int unsigned IDX_SRCL = 6;
    localparam int unsigned IDX_SRCH = 7;
    localparam int unsigned IDX_TMR  = 8;
    localparam int unsigned IDX_WAIT = 9;
    localparam int unsigned IDX_SER  = 10;
    localparam int unsigned IDX_IEN  = 11;
    localparam int unsigned IDX_IFLG = 12;
    localparam int unsigned IDX_DBG  = 13;

    localparam logic [15:0] MSK_STAT = 16'hFFF8;
    localparam logic [15:0] MSK_SNDM = 16'h0080;
    localparam logic [15:0] MSK_TMR  = 16'h00C7;
    localparam logic [15:0] MSK_WAIT = 16'h5FFF;
    localparam logic [15:0] MSK_SER  = 16'hC1FF;
    localparam logic [15:0] DBG_KEY  = 16'hC0DE;
    localparam logic [15:0] DBG_ID   = 16'h1DEA;

    localparam int unsigned SND_EN_BIT = 7;

    // Next stored value of slot idx for an already byte-merged write value.
    function automatic logic [15:0] apply_rule(int unsigned idx,
                                               logic [15:0] old,
                                               logic [15:0] val);
        case (idx)
            IDX_STAT: return val & MSK_STAT;
            IDX_LINE: return old;
            IDX_SNDM: return val & MSK_SNDM;
            IDX_TMR:  return val & MSK_TMR;
            IDX_WAIT: return val & MSK_WAIT;
            IDX_SER:  return val & MSK_SER;
            IDX_IFLG: return old & ~val;
            default:  return val;
        endcase
    endfunction

endpackage

// File: rtl/regbank_lane.sv
// One halfword access lane: decodes whether the slot is mapped and merges
// the lane's bytes with the stored halfword. Assumes byte enables are
// already resolved by the top level.
module regbank_lane
    import regbank_pkg::*;
#(
    parameter int unsigned IW = 7
) (
    input  logic              en,
    input  logic [IW-1:0]     idx,
    input  logic [1:0]        be,
    input  logic [15:0]       data,
    input  logic [NREG*HW-1:0] mem_flat,
    output logic              mapped,
    output logic              wr,
    output logic [15:0]       merged
);

    logic [15:0] old;

    // Slot decode and byte merge against the stored halfword.
    always_comb begin
        mapped = (32'(idx) < NREG);
        old    = mapped ? mem_flat[int'(idx)*HW +: HW] : '0;
        merged = {be[1] ? data[15:8] : old[15:8],
                  be[0] ? data[7:0]  : old[7:0]};
        wr     = en && mapped;
    end

endmodule

// File: rtl/regbank_store.sv
// Storage for all slots. Each slot applies its write rule from the package;
// the interrupt-flag slot also ORs in irq_set after any clear. Assumes the
// two lanes never target the same slot in one cycle.
module regbank_store
    import regbank_pkg::*;
#(
    parameter int unsigned IW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr0,
    input  logic [IW-1:0]      idx0,
    input  logic [15:0]        val0,
    input  logic               wr1,
    input  logic [IW-1:0]      idx1,
    input  logic [15:0]        val1,
    input  logic [15:0]        irq_set,
    output logic [NREG*HW-1:0] mem_flat
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic [15:0] q;
        logic [15:0] d;
        logic        hit0;
        logic        hit1;

        // Next value: lane write through the slot rule, then flag sets.
        always_comb begin
            hit0 = wr0 && (32'(idx0) == 32'(g));
            hit1 = wr1 && (32'(idx1) == 32'(g));
            d    = q;
            if (hit0)      d = apply_rule(g, q, val0);
            else if (hit1) d = apply_rule(g, q, val1);
            if (g == IDX_IFLG) d = d | irq_set;
        end

        // Slot register with synchronous reset to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign mem_flat[g*HW +: HW] = q;

        if (g == IDX_IFLG) begin : g_flag_chk
            // R3: a flag bit only rises in a cycle after irq_set drove it
            a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
                (q & ~$past(q) & ~$past(irq_set)) == 16'h0000);
        end
        if (g == IDX_TMR) begin : g_tmr_chk
            a_r9_timer_mask: assert property (@(posedge clk) disable iff (!rst_n)
                (q & ~MSK_TMR) == 16'h0000);
        end
        if (g == IDX_SER) begin : g_ser_chk
            a_r9_serial_mask: assert property (@(posedge clk) disable iff (!rst_n)
                (q & ~MSK_SER) == 16'h0000);
        end
        if (g == IDX_LINE) begin : g_line_chk
            a_r4_line_never_stored: assert property (@(posedge clk) disable iff (!rst_n)
                q == 16'h0000);
        end
    end

endmodule

// File: rtl/regbank_rdview.sv
// Read shaping for one lane: live status bits, read-only counter, gated
// sound channels, write-only slots and the debug identity value. Assumes
// mapped comes from the matching lane decode.
module regbank_rdview
    import regbank_pkg::*;
#(
    parameter int unsigned IW     = 7,
    parameter int unsigned LINE_W = 8
) (
    input  logic [IW-1:0]       idx,
    input  logic                mapped,
    input  logic [NREG*HW-1:0]  mem_flat,
    input  logic [STAT_W-1:0]   stat_in,
    input  logic [LINE_W-1:0]   line_in,
    input  logic [CHAN_W-1:0]   chan_in,
    output logic [15:0]         rd
);

    logic [15:0] q;
    logic        snd_on;
    logic        unlocked;

    // Select the stored halfword and apply the slot's read rule.
    always_comb begin
        q        = mapped ? mem_flat[int'(idx)*HW +: HW] : '0;
        snd_on   = mem_flat[IDX_SNDM*HW + SND_EN_BIT];
        unlocked = (mem_flat[IDX_DBG*HW +: HW] == DBG_KEY);
        rd       = '0;
        if (mapped) begin
            case (32'(idx))
                IDX_STAT: rd = {q[15:STAT_W], stat_in};
                IDX_LINE: rd = 16'(line_in);
                IDX_SNDM: rd = {8'h00, q[SND_EN_BIT], 3'b000, chan_in};
                IDX_CH0, IDX_CH1: rd = snd_on ? q : 16'h0000;
                IDX_DCNT, IDX_SRCL, IDX_SRCH: rd = 16'h0000;
                IDX_DBG:  rd = unlocked ? DBG_ID : 16'h0000;
                default:  rd = q;
            endcase
        end
    end

endmodule

// File: rtl/periph_regbank.sv
// Top of the peripheral register bank. Splits each bus request into one or
// two halfword lanes, stores writes, shapes reads and registers the read
// data, read-valid and error strobes. Assumes one request per cycle with no
// back-pressure.
module periph_regbank
    import regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LINE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [1:0]          size,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                rvalid,
    output logic                err,
    input  logic [2:0]          stat_in,
    input  logic [LINE_W-1:0]   line_in,
    input  logic [3:0]          chan_in,
    input  logic [15:0]         irq_set,
    output logic [NREG*HW-1:0]  reg_view,
    output logic                dbg_on
);

    localparam int unsigned IW = ADDR_W - 1;

    logic              is_word, is_byte, is_rd, is_wr;
    logic [IW-1:0]     idx0, idx1;
    logic [1:0]        be0;
    logic [15:0]       d0;
    logic              map0, map1, wr0, wr1;
    logic [15:0]       val0, val1, rv0, rv1;
    logic [31:0]       rsel;
    logic [NREG*HW-1:0] mem_flat;
    logic              err_d;
    logic              snd_on;

    // Request decode into lane indices, byte enables and lane data.
    always_comb begin
        is_word = size[1];
        is_byte = (size == 2'b00);
        is_rd   = req && !we;
        is_wr   = req && we;
        idx0    = is_word ? {addr[ADDR_W-1:2], 1'b0} : addr[ADDR_W-1:1];
        idx1    = {addr[ADDR_W-1:2], 1'b1};
        be0     = is_byte ? (addr[0] ? 2'b10 : 2'b01) : 2'b11;
        d0      = is_byte ? {wdata[7:0], wdata[7:0]} : wdata[15:0];
    end

    regbank_lane #(.IW(IW)) u_lane0 (
        .en(is_wr), .idx(idx0), .be(be0), .data(d0), .mem_flat(mem_flat),
        .mapped(map0), .wr(wr0), .merged(val0)
    );

    regbank_lane #(.IW(IW)) u_lane1 (
        .en(is_wr && is_word), .idx(idx1), .be(2'b11), .data(wdata[31:16]),
        .mem_flat(mem_flat), .mapped(map1), .wr(wr1), .merged(val1)
    );

    regbank_store #(.IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr0(wr0), .idx0(idx0), .val0(val0),
        .wr1(wr1), .idx1(idx1), .val1(val1),
        .irq_set(irq_set), .mem_flat(mem_flat)
    );

    regbank_rdview #(.IW(IW), .LINE_W(LINE_W)) u_rd0 (
        .idx(idx0), .mapped(map0), .mem_flat(mem_flat), .stat_in(stat_in),
        .line_in(line_in), .chan_in(chan_in), .rd(rv0)
    );

    regbank_rdview #(.IW(IW), .LINE_W(LINE_W)) u_rd1 (
        .idx(idx1), .mapped(map1), .mem_flat(mem_flat), .stat_in(stat_in),
        .line_in(line_in), .chan_in(chan_in), .rd(rv1)
    );

    // Read data assembly by access size, and the unmapped-access error.
    always_comb begin
        if (is_word)      rsel = {rv1, rv0};
        else if (is_byte) rsel = {24'h000000, addr[0] ? rv0[15:8] : rv0[7:0]};
        else              rsel = {16'h0000, rv0};
        err_d = req && (!map0 || (is_word && !map1));
    end

    // Registered bus response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            err    <= 1'b0;
        end else begin
            rdata  <= is_rd ? rsel : '0;
            rvalid <= is_rd;
            err    <= err_d;
        end
    end

    assign reg_view = mem_flat;
    assign dbg_on   = (mem_flat[IDX_DBG*HW +: HW] == DBG_KEY);
    assign snd_on   = mem_flat[IDX_SNDM*HW + SND_EN_BIT];

    // R11: err only follows a request
    a_r11_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req));

    // R12: rvalid only follows a read request
    a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && !we));

    a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'b01 && !map0) |=> rdata == 32'h0);

    a_r4_line_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'b01 && 32'(idx0) == IDX_LINE)
        |=> rdata == 32'($past(line_in)));

    a_r10_debug_id: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'b01 && 32'(idx0) == IDX_DBG && dbg_on)
        |=> rdata == {16'h0000, DBG_ID});

    a_r7_gated_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'b01 && !snd_on &&
         (32'(idx0) == IDX_CH0 || 32'(idx0) == IDX_CH1))
        |=> rdata == 32'h0);

endmodule

// File: tb/sim_periph_regbank.sv
// Directed bench for periph_regbank: one task per scenario.
module sim_periph_regbank;

    localparam int unsigned NREG = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [1:0]        size = 2'b01;
    logic [7:0]        addr = 8'h00;
    logic [31:0]       wdata = 32'h0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic              err;
    logic [2:0]        stat_in = 3'b101;
    logic [7:0]        line_in = 8'h9A;
    logic [3:0]        chan_in = 4'b0101;
    logic [15:0]       irq_set = 16'h0;
    logic [NREG*16-1:0] reg_view;
    logic              dbg_on;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    periph_regbank u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .err(err), .stat_in(stat_in), .line_in(line_in), .chan_in(chan_in),
        .irq_set(irq_set), .reg_view(reg_view), .dbg_on(dbg_on)
    );

    function automatic logic [15:0] slot(int i);
        return reg_view[i*16 +: 16];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sz, input logic [7:0] a,
                          input logic [31:0] d, output logic e);
        @(negedge clk);
        req = 1'b1; we = 1'b1; size = sz; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        e = err;
        chk("R12 rvalid low after write", 32'(rvalid), 32'd0);
    endtask

    task automatic bus_rd(input logic [1:0] sz, input logic [7:0] a,
                          output logic [31:0] q, output logic e);
        @(negedge clk);
        req = 1'b1; we = 1'b0; size = sz; addr = a;
        @(negedge clk);
        req = 1'b0;
        q = rdata;
        e = err;
        chk("R12 rvalid one cycle after read", 32'(rvalid), 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] q; logic e;
        chk("R12 reset slots zero", 32'(reg_view == '0), 32'd1);
        chk("R12 reset rvalid", 32'(rvalid), 32'd0);
        chk("R11 reset err", 32'(err), 32'd0);
        chk("R10 reset dbg_on", 32'(dbg_on), 32'd0);
        bus_rd(2'b01, 8'h16, q, e);
        chk("R12 interrupt enable resets to 0", q, 32'h0);
    endtask

    task automatic t_line();
        logic [31:0] q; logic e;
        bus_wr(2'b01, 8'h02, 32'hFFFF, e);
        chk("R4 write leaves slot empty", 32'(slot(1)), 32'h0);
        bus_rd(2'b01, 8'h02, q, e);
        chk("R4 reads line_in", q, 32'h009A);
    endtask

    task automatic t_stat();
        logic [31:0] q; logic e;
        bus_wr(2'b01, 8'h00, 32'hFFFF, e);
        chk("R5 stored upper bits only", 32'(slot(0)), 32'hFFF8);
        stat_in = 3'b010;
        bus_rd(2'b01, 8'h00, q, e);
        chk("R5 low bits follow stat_in", q, 32'hFFFA);
    endtask

    task automatic t_gate_and_master();
        logic [31:0] q; logic e;
        bus_wr(2'b01, 8'h08, 32'h5555, e);
        chk("R7 write stored while disabled", 32'(slot(4)), 32'h5555);
        bus_rd(2'b01, 8'h08, q, e);
        chk("R7 gated read is zero", q, 32'h0);
        bus_wr(2'b01, 8'h04, 32'hFFFF, e);
        chk("R6 only bit 7 stored", 32'(slot(2)), 32'h0080);
        bus_rd(2'b01, 8'h04, q, e);
        chk("R6 read with channel status", q, 32'h0085);
        bus_rd(2'b01, 8'h08, q, e);
        chk("R7 enabled read returns stored", q, 32'h5555);
    endtask

    task automatic t_byte();
        logic [31:0] q; logic e;
        bus_wr(2'b01, 8'h06, 32'h1234, e);
        bus_wr(2'b00, 8'h07, 32'h000000AB, e);
        chk("R1 odd byte replaces upper", 32'(slot(3)), 32'hAB34);
        bus_wr(2'b00, 8'h06, 32'h000000CD, e);
        chk("R1 even byte replaces lower", 32'(slot(3)), 32'hABCD);
        bus_rd(2'b00, 8'h07, q, e);
        chk("R1 byte read upper", q, 32'h000000AB);
    endtask

    task automatic t_word();
        logic [31:0] q; logic e;
        bus_wr(2'b10, 8'h0E, 32'hDEADBEEF, e);
        chk("R2 low half to aligned slot", 32'(slot(6)), 32'hBEEF);
        chk("R2 high half to next slot", 32'(slot(7)), 32'hDEAD);
        bus_wr(2'b10, 8'h10, 32'h12345678, e);
        bus_rd(2'b10, 8'h10, q, e);
        chk("R2 word read of masked pair", q, 32'h12340040);
    endtask

    task automatic t_masks();
        logic [31:0] q; logic e;
        bus_wr(2'b01, 8'h10, 32'hFFFF, e);
        chk("R9 timer mask", 32'(slot(8)), 32'h00C7);
        bus_wr(2'b01, 8'h12, 32'hFFFF, e);
        chk("R9 wait mask", 32'(slot(9)), 32'h5FFF);
        bus_wr(2'b01, 8'h14, 32'hFFFF, e);
        bus_rd(2'b01, 8'h14, q, e);
        chk("R9 serial mask", q, 32'hC1FF);
    endtask

    task automatic t_write_only();
        logic [31:0] q; logic e;
        bus_wr(2'b01, 8'h0A, 32'h0100, e);
        chk("R8 count stored", 32'(slot(5)), 32'h0100);
        bus_rd(2'b01, 8'h0A, q, e);
        chk("R8 count reads zero", q, 32'h0);
        bus_rd(2'b10, 8'h0C, q, e);
        chk("R8 address reads zero", q, 32'h0);
    endtask

    task automatic t_irq();
        logic e;
        @(negedge clk); irq_set = 16'h00F0;
        @(negedge clk); irq_set = 16'h0000;
        chk("R3 set pulses", 32'(slot(12)), 32'h00F0);
        bus_wr(2'b01, 8'h18, 32'h0030, e);
        chk("R3 ones clear", 32'(slot(12)), 32'h00C0);
        bus_wr(2'b01, 8'h18, 32'h0000, e);
        chk("R3 zeros keep", 32'(slot(12)), 32'h00C0);
        @(negedge clk);
        req = 1'b1; we = 1'b1; size = 2'b01; addr = 8'h18; wdata = 32'h00C0;
        irq_set = 16'h0040;
        @(negedge clk);
        req = 1'b0; we = 1'b0; irq_set = 16'h0;
        chk("R3 set wins over clear", 32'(slot(12)), 32'h0040);
        @(negedge clk); irq_set = 16'h0100;
        @(negedge clk); irq_set = 16'h0000;
        chk("R3 second set", 32'(slot(12)), 32'h0140);
        bus_wr(2'b00, 8'h18, 32'h00000000, e);
        chk("R3 byte write clears other byte", 32'(slot(12)), 32'h0040);
    endtask

    task automatic t_dbg();
        logic [31:0] q; logic e;
        bus_wr(2'b01, 8'h1A, 32'hC0DE, e);
        chk("R10 unlock", 32'(dbg_on), 32'd1);
        bus_rd(2'b01, 8'h1A, q, e);
        chk("R10 identity read", q, 32'h1DEA);
        bus_wr(2'b01, 8'h1A, 32'hC0DF, e);
        chk("R10 other value locks", 32'(dbg_on), 32'd0);
        bus_rd(2'b01, 8'h1A, q, e);
        chk("R10 locked read", q, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] q; logic e;
        logic [NREG*16-1:0] snap;
        snap = reg_view;
        bus_wr(2'b01, 8'h40, 32'hFFFF, e);
        chk("R11 write err", 32'(e), 32'd1);
        chk("R11 nothing stored", 32'(reg_view == snap), 32'd1);
        bus_rd(2'b01, 8'h40, q, e);
        chk("R11 read zero", q, 32'h0);
        chk("R11 read err", 32'(e), 32'd1);
        bus_wr(2'b10, 8'h1C, 32'hFFFFFFFF, e);
        chk("R11 word lane miss err", 32'(e), 32'd1);
        chk("R11 word miss stores nothing", 32'(reg_view == snap), 32'd1);
        bus_rd(2'b01, 8'h16, q, e);
        chk("R11 mapped access no err", 32'(e), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_line();
        t_stat();
        t_gate_and_master();
        t_byte();
        t_word();
        t_masks();
        t_write_only();
        t_irq();
        t_dbg();
        t_unmapped();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule